// File: doc/BRIEF.md
# Dual-Channel DAC Serial Control Front End

This block is the digital control logic for a two-channel, 12-bit voltage-output converter. A host writes 16-bit command words through a three-wire serial port. The port has an active-low select, a serial clock and a data input. The same shift register returns the bits on a serial data output, so several devices can be daisy-chained. Each word holds a 4-bit command in its top bits and a 12-bit code in its low bits. Each channel keeps a staging (input) register and a live (DAC) register. A host can therefore stage new codes for both channels and then move them to the live registers together.

Further commands power down one channel or both, and set or clear a general-purpose output pin. A lockout input blocks all power-down commands while it is low. An asynchronous active-low clear returns every register to zero. The serial pins are oversampled by the block clock. The port has no back-pressure: the host owns the timing, and a word is acted on only when exactly 16 clock rises occur inside one select window. The live codes and the power-down flags drive the analog section, which is outside this block.

Top module: `dac_serial_ctrl`

## Requirements
- R1: While `clr_n` is low, both codes, both power-down flags, `gpo` and `sdo` are 0 at once, with no clock edge needed.
- R2: Bits are taken MSB first on rising `sclk` while `cs_n` is low. A word is acted on at the rising edge of `cs_n` only when exactly 16 bits were shifted. Shorter and longer frames change no output except `sdo`.
- R3: Command 1 stores the data field in the channel A staging register and command 2 stores it in the channel B staging register. Neither changes a live code.
- R4: Command 3 (for A) and command 4 (for B) store the data field in that channel's staging register. In the same step, both live registers load from the staging registers, including the newly stored value.
- R5: Command 5 copies both staging registers into both live registers.
- R6: Command 6 powers down A, 7 powers down B and 8 powers down both. Staging and live contents are kept across power-down.
- R7: While `pd_lock_n` is low, commands 6, 7 and 8 have no effect on either flag.
- R8: Commands 1 and 3 clear the A power-down flag. Commands 2 and 4 clear the B flag.
- R9: Command 9 sets `gpo` and command 10 clears it.
- R10: `sdo` is the bit that entered `sdi` 16 shifts earlier. It is taken from the MSB of the shift register.
- R11: Words keep being decoded while channels are powered down. Command 5 then updates the live codes and leaves the flags set.
- R12: Commands 0 and 11 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that oversamples the serial pins |
| clr_n | input | 1 | Asynchronous active-low clear of all state |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock; data taken on its rising edge |
| sdi | input | 1 | Serial data in, MSB first |
| pd_lock_n | input | 1 | Low blocks power-down commands |
| sdo | output | 1 | Serial data out (shift register MSB) |
| code_a | output | 12 | Live code of channel A |
| code_b | output | 12 | Live code of channel B |
| pd_a | output | 1 | Channel A powered down |
| pd_b | output | 1 | Channel B powered down |
| gpo | output | 1 | User-programmable output pin |

## Verification
A staging register that holds a wrong value stays hidden until a later update command copies it to a live code. The stimulus therefore always follows staging loads with an update, and the check lands a few clocks after that word's select edge. A wrong bit count or a wrong shift shows on `sdo` within one serial clock, because the output is compared after every shifted bit. A power-down flag that leaks past the lockout, or that is not cleared by a load, shows on `pd_a`/`pd_b` three clocks after the frame closes.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;
  localparam int CMD_W = 4;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP      = 4'd0,
    CMD_LD_A     = 4'd1,
    CMD_LD_B     = 4'd2,
    CMD_LD_A_UPD = 4'd3,
    CMD_LD_B_UPD = 4'd4,
    CMD_UPD      = 4'd5,
    CMD_PD_A     = 4'd6,
    CMD_PD_B     = 4'd7,
    CMD_PD_AB    = 4'd8,
    CMD_GPO_SET  = 4'd9,
    CMD_GPO_CLR  = 4'd10
  } dac_cmd_e;

  localparam int NCH = 2;
endpackage

// File: rtl/serial_word_rx.sv
module serial_word_rx #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               clr_n,
  input  logic               cs_n,
  input  logic               sclk,
  input  logic               sdi,
  output logic [FRAME_W-1:0] word_o,
  output logic               word_vld_o,
  output logic               sdo
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

  logic s_sclk, s_cs, s_sdi, p_sclk, p_cs;
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   cnt;
  logic               vld_q;
  logic               sclk_rise, cs_rise, cs_fall;

  assign sclk_rise = s_sclk & ~p_sclk & ~s_cs;
  assign cs_rise   = s_cs & ~p_cs;
  assign cs_fall   = ~s_cs & p_cs;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      s_sclk <= 1'b0;
      s_cs   <= 1'b1;
      s_sdi  <= 1'b0;
      p_sclk <= 1'b0;
      p_cs   <= 1'b1;
    end else begin
      s_sclk <= sclk;
      s_cs   <= cs_n;
      s_sdi  <= sdi;
      p_sclk <= s_sclk;
      p_cs   <= s_cs;
    end
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      shreg <= '0;
      cnt   <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= cs_rise && (cnt == CNT_FULL);
      if (cs_rise || cs_fall) begin
        cnt <= '0;
      end else if (sclk_rise && cnt != CNT_OVER) begin
        cnt <= cnt + 1'b1;
      end
      if (sclk_rise) begin
        shreg <= {shreg[FRAME_W-2:0], s_sdi};
      end
    end
  end

  assign word_o     = shreg;
  assign word_vld_o = vld_q;
  assign sdo        = shreg[FRAME_W-1];

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!clr_n)
    (s_cs && p_cs) |=> $stable(shreg));
  assert_vld_single_R2: assert property (@(posedge clk) disable iff (!clr_n)
    word_vld_o |=> !word_vld_o);
endmodule

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import dac_ctrl_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic [CMD_W+DATA_W-1:0] word_i,
  input  logic                    vld_i,
  input  logic                    lock_n_i,
  output logic [NCH-1:0]          ld_o,
  output logic                    upd_o,
  output logic [NCH-1:0]          pd_set_o,
  output logic                    gpo_set_o,
  output logic                    gpo_clr_o
);
  logic [CMD_W-1:0] cmd;
  assign cmd = word_i[CMD_W+DATA_W-1:DATA_W];

  always_comb begin
    ld_o      = '0;
    upd_o     = 1'b0;
    pd_set_o  = '0;
    gpo_set_o = 1'b0;
    gpo_clr_o = 1'b0;
    if (vld_i) begin
      case (cmd)
        CMD_LD_A:     ld_o[0] = 1'b1;
        CMD_LD_B:     ld_o[1] = 1'b1;
        CMD_LD_A_UPD: begin ld_o[0] = 1'b1; upd_o = 1'b1; end
        CMD_LD_B_UPD: begin ld_o[1] = 1'b1; upd_o = 1'b1; end
        CMD_UPD:      upd_o = 1'b1;
        CMD_PD_A:     pd_set_o[0] = lock_n_i;
        CMD_PD_B:     pd_set_o[1] = lock_n_i;
        CMD_PD_AB:    pd_set_o = {NCH{lock_n_i}};
        CMD_GPO_SET:  gpo_set_o = 1'b1;
        CMD_GPO_CLR:  gpo_clr_o = 1'b1;
        default:      ;
      endcase
    end
  end
endmodule

// File: rtl/dac_channel.sv
module dac_channel #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              ld_i,
  input  logic              upd_i,
  input  logic              pd_set_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] dac_o,
  output logic              pd_o
);
  logic [DATA_W-1:0] in_q, dac_q;
  logic              pd_q;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      in_q  <= '0;
      dac_q <= '0;
      pd_q  <= 1'b0;
    end else begin
      if (ld_i) in_q <= data_i;
      if (upd_i) dac_q <= ld_i ? data_i : in_q;
      if (pd_set_i) pd_q <= 1'b1;
      else if (ld_i) pd_q <= 1'b0;
    end
  end

  assign dac_o = dac_q;
  assign pd_o  = pd_q;

  assert_live_hold_R3: assert property (@(posedge clk) disable iff (!clr_n)
    !upd_i |=> $stable(dac_q));
  assert_stage_keep_R6: assert property (@(posedge clk) disable iff (!clr_n)
    !ld_i |=> $stable(in_q));
endmodule

// File: rtl/dac_serial_ctrl.sv
module dac_serial_ctrl
  import dac_ctrl_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              pd_lock_n,
  output logic              sdo,
  output logic [DATA_W-1:0] code_a,
  output logic [DATA_W-1:0] code_b,
  output logic              pd_a,
  output logic              pd_b,
  output logic              gpo
);
  localparam int FRAME_W = CMD_W + DATA_W;

  logic [FRAME_W-1:0] word;
  logic               word_vld;
  logic [NCH-1:0]     ld, pd_set, pd_vec;
  logic               upd, gpo_set, gpo_clr, gpo_q;
  logic [DATA_W-1:0]  code_vec [NCH];

  serial_word_rx #(.FRAME_W(FRAME_W)) u_rx (
    .clk(clk), .clr_n(clr_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .word_o(word), .word_vld_o(word_vld), .sdo(sdo)
  );

  dac_cmd_decode #(.DATA_W(DATA_W)) u_dec (
    .word_i(word), .vld_i(word_vld), .lock_n_i(pd_lock_n),
    .ld_o(ld), .upd_o(upd), .pd_set_o(pd_set),
    .gpo_set_o(gpo_set), .gpo_clr_o(gpo_clr)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dac_channel #(.DATA_W(DATA_W)) u_ch (
      .clk(clk), .clr_n(clr_n), .ld_i(ld[i]), .upd_i(upd),
      .pd_set_i(pd_set[i]), .data_i(word[DATA_W-1:0]),
      .dac_o(code_vec[i]), .pd_o(pd_vec[i])
    );
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)       gpo_q <= 1'b0;
    else if (gpo_set) gpo_q <= 1'b1;
    else if (gpo_clr) gpo_q <= 1'b0;
  end

  assign code_a = code_vec[0];
  assign code_b = code_vec[1];
  assign pd_a   = pd_vec[0];
  assign pd_b   = pd_vec[1];
  assign gpo    = gpo_q;

  assert_code_on_frame_R2: assert property (@(posedge clk) disable iff (!clr_n)
    (code_a != $past(code_a) || code_b != $past(code_b)) |-> $past(word_vld));
  assert_gpo_on_frame_R9: assert property (@(posedge clk) disable iff (!clr_n)
    (gpo != $past(gpo)) |-> $past(word_vld));
  assert_lock_veto_a_R7: assert property (@(posedge clk) disable iff (!clr_n)
    $rose(pd_a) |-> $past(pd_lock_n));
  assert_lock_veto_b_R7: assert property (@(posedge clk) disable iff (!clr_n)
    $rose(pd_b) |-> $past(pd_lock_n));
endmodule

// File: tb/tb_dac_serial_ctrl.sv
module tb_dac_serial_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic clr_n, cs_n, sclk, sdi, pd_lock_n;
  logic sdo, pd_a, pd_b, gpo;
  logic [11:0] code_a, code_b;

  typedef struct packed {
    logic [11:0] a;
    logic [11:0] b;
    logic        pa;
    logic        pb;
    logic        g;
  } exp_t;

  exp_t exp_q[$];
  event frame_ev;
  int total = 0, bad = 0;
  bit done = 1'b0;

  logic [11:0] m_ia, m_ib, m_da, m_db;
  logic        m_pa, m_pb, m_g;
  logic [15:0] m_sh;

  dac_serial_ctrl dut (
    .clk(clk), .clr_n(clr_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .pd_lock_n(pd_lock_n), .sdo(sdo), .code_a(code_a), .code_b(code_b),
    .pd_a(pd_a), .pd_b(pd_b), .gpo(gpo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ia = '0; m_ib = '0; m_da = '0; m_db = '0;
    m_pa = 1'b0; m_pb = 1'b0; m_g = 1'b0; m_sh = '0;
  endtask

  task automatic model_apply(input logic [15:0] w);
    logic [11:0] d;
    d = w[11:0];
    case (w[15:12])
      4'd1: begin m_ia = d; m_pa = 1'b0; end
      4'd2: begin m_ib = d; m_pb = 1'b0; end
      4'd3: begin m_ia = d; m_pa = 1'b0; m_da = m_ia; m_db = m_ib; end
      4'd4: begin m_ib = d; m_pb = 1'b0; m_da = m_ia; m_db = m_ib; end
      4'd5: begin m_da = m_ia; m_db = m_ib; end
      4'd6: if (pd_lock_n) m_pa = 1'b1;
      4'd7: if (pd_lock_n) m_pb = 1'b1;
      4'd8: if (pd_lock_n) begin m_pa = 1'b1; m_pb = 1'b1; end
      4'd9: m_g = 1'b1;
      4'd10: m_g = 1'b0;
      default: ;
    endcase
  endtask

  // Driver: shifts a frame of n bits MSB first, checks sdo per bit (R10),
  // updates the model and pushes the expected state to the scoreboard.
  task automatic send(input logic [31:0] val, input int n);
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = val[i];
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      m_sh = {m_sh[14:0], val[i]};
      repeat (HALF) @(negedge clk);
      chk("R10 sdo", {31'd0, sdo}, {31'd0, m_sh[15]});
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    if (n == 16) model_apply(val[15:0]);
    exp_q.push_back('{a: m_da, b: m_db, pa: m_pa, pb: m_pb, g: m_g});
    -> frame_ev;
    repeat (2 * HALF) @(negedge clk);
  endtask

  // Monitor: pops and compares after the frame has been decoded.
  initial begin
    forever begin
      exp_t e;
      @(frame_ev);
      repeat (4) @(negedge clk);
      e = exp_q.pop_front();
      chk("R2-R12 code_a", {20'd0, code_a}, {20'd0, e.a});
      chk("R2-R12 code_b", {20'd0, code_b}, {20'd0, e.b});
      chk("R6/R7/R8 pd_a", {31'd0, pd_a}, {31'd0, e.pa});
      chk("R6/R7/R8 pd_b", {31'd0, pd_b}, {31'd0, e.pb});
      chk("R9 gpo", {31'd0, gpo}, {31'd0, e.g});
    end
  end

  task automatic check_cleared();
    chk("R1 code_a", {20'd0, code_a}, 32'd0);
    chk("R1 code_b", {20'd0, code_b}, 32'd0);
    chk("R1 pd_a", {31'd0, pd_a}, 32'd0);
    chk("R1 pd_b", {31'd0, pd_b}, 32'd0);
    chk("R1 gpo", {31'd0, gpo}, 32'd0);
    chk("R1 sdo", {31'd0, sdo}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    clr_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0; pd_lock_n = 1'b1;
    model_reset();
    #3;
    check_cleared();                 // R1 before any edge
    repeat (3) @(negedge clk);
    clr_n = 1'b1;
    repeat (2) @(negedge clk);

    send(32'h1ABC, 16);              // R3 stage A only
    send(32'h2123, 16);              // R3 stage B only
    send(32'h5000, 16);              // R5 update both
    send(32'h3FFF, 16);              // R4 load A + update
    send(32'h4000, 16);              // R4 load B + update
    pd_lock_n = 1'b0;
    send(32'h8000, 16);              // R7 veto
    send(32'h6000, 16);              // R7 veto
    pd_lock_n = 1'b1;
    send(32'h1321, 16);              // stage A
    send(32'h6000, 16);              // R6 power down A
    send(32'h7000, 16);              // R6 power down B
    send(32'h5000, 16);              // R11 update while down, R6 staging kept
    send(32'h1555, 16);              // R8 wake A
    send(32'h5000, 16);              // R11 B still down
    send(32'h2AAA, 16);              // R8 wake B
    send(32'h9000, 16);              // R9 set
    send(32'hA000, 16);              // R9 clear
    send(32'h9000, 16);              // R9 set
    send(32'h3777, 15);              // R2 short frame discarded
    send(32'h1_3777, 17);            // R2 long frame discarded
    send(32'h5000, 16);              // R2 confirm staging untouched
    send(32'hB123, 16);              // R12
    send(32'hF0FF, 16);              // R12
    send(32'h0FFF, 16);              // R12
    send(32'h5000, 16);              // R12 confirm staging untouched
    send(32'h8000, 16);              // R6 both down

    #2;
    clr_n = 1'b0;                    // R1 asynchronous clear
    #1;
    check_cleared();
    model_reset();
    repeat (2) @(negedge clk);
    clr_n = 1'b1;
    repeat (2) @(negedge clk);
    send(32'h3800, 16);              // R4 after clear, B stays 0

    repeat (4 * HALF) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule